// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block sits between a processor's execute stage and an attached coprocessor. It steps one coprocessor instruction through its handshake. There are five operation kinds: a register value sent to the coprocessor, a value read back from it, an internal data operation, and multi-word loads and stores that the coprocessor feeds or drains through memory.

After a start strobe the sequencer offers the instruction to the coprocessor and reads the two-bit response code. On a busy response it spends one idle cycle. In that idle cycle it checks the interrupt lines, and it either polls again or abandons the instruction. For loads and stores it drives a word-addressed memory request port and advances the address while the coprocessor asks for more words.

Every instruction ends in a single-cycle `done` pulse with an exception code. The code reports a normal finish, an undefined instruction, an interrupt that won during a busy wait, an address abort or a data abort.

Top module: `cp_handshake_seq`

## Requirements
- R1: After reset `cp_valid`, `mem_req`, `wb_valid`, `rd_valid` and `done` are all low.
- R2: In the cycle after `start`, `cp_valid` is high with `cp_phase` = 0 (offer) and `cp_instr` equal to the started instruction. A data operation (`op_sel` = 2) that is accepted at once reports `done` in the second cycle after `start`, with `exc_code` 0 (none).
- R3: The response codes are 00 accept, 01 busy, 10 cannot and 11 increment. Each busy answer adds one idle cycle with `cp_valid` low, followed by a re-poll with `cp_phase` = 1. An accepted data operation after n busy answers therefore finishes in 2+2n cycles.
- R4: In an idle cycle of a busy wait, a pending unmasked interrupt ends the instruction. It presents one cycle with `cp_phase` = 2 (interrupt notice), and then `done` follows with that interrupt's exception code and no read result.
- R5: Interrupt ranking is: reset request (`rst_req_n` low, code 2), then fast interrupt (`fiq_n` low with `f_mask` clear, code 3), then normal interrupt (`irq_n` low with `i_mask` clear, code 4). A masked interrupt has no effect and polling continues.
- R6: A cannot answer to the offer or to a re-poll ends the instruction with `exc_code` 1 (undefined). For a read from the coprocessor (`op_sel` = 1), `rd_valid` is also raised with the condition `flags` placed in the top bits of `rd_data` and zeros below.
- R7: An accepted send to the coprocessor (`op_sel` = 0) takes one transfer cycle (`cp_phase` = 3) that carries the latched `reg_wdata` on `cp_wdata`, and finishes in 3 cycles. An accepted read takes one transfer cycle and one internal cycle, finishes in 4 cycles, and returns `cp_rdata` on `rd_data`.
- R8: An accepted load (`op_sel` = 3) or store (`op_sel` = 4) moves its first word at `base_addr` with `cp_phase` = 4. Each increment answer moves one more word at the address plus 4; any other answer ends the transfer.
- R9: A load or store whose base address has any bit at or above `ADDR_SPACE_BITS` set ends at once with code 6 (address abort) and no handshake. A store below `VEC_BYTES` does the same, while a load there proceeds normally.
- R10: When bit 21 of the instruction is set, `wb_valid` pulses once, with the latched `wb_value`, in the first memory cycle. Otherwise it stays low.
- R11: If `mem_abort` is high in any memory cycle, all requested words are still moved and the instruction ends with code 5 (data abort).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new instruction (sampled when idle) |
| op_sel | input | 3 | Operation kind: 0 send, 1 read, 2 data op, 3 load, 4 store |
| instr | input | IW | Instruction word |
| base_addr | input | AW | First word address for loads and stores |
| wb_value | input | AW | Base register writeback value |
| reg_wdata | input | DW | Register value for a send |
| flags | input | FW | Current condition flags |
| rst_req_n | input | 1 | Reset request, active low |
| fiq_n | input | 1 | Fast interrupt, active low |
| irq_n | input | 1 | Normal interrupt, active low |
| f_mask | input | 1 | Fast interrupt mask |
| i_mask | input | 1 | Normal interrupt mask |
| cp_valid | output | 1 | Coprocessor strobe |
| cp_phase | output | 3 | Handshake phase code |
| cp_instr | output | IW | Instruction presented to the coprocessor |
| cp_resp | input | 2 | Coprocessor response code |
| cp_wdata | output | DW | Register value sent to the coprocessor |
| cp_rdata | input | DW | Value read from the coprocessor |
| cp_ldata | output | DW | Loaded memory word passed to the coprocessor |
| cp_sdata | input | DW | Word from the coprocessor to store |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| mem_abort | input | 1 | Memory abort |
| wb_valid | output | 1 | Base writeback commit pulse |
| wb_data | output | AW | Base writeback value |
| rd_valid | output | 1 | Read result valid (with done) |
| rd_data | output | DW | Read result |
| done | output | 1 | Instruction finished |
| exc_code | output | 3 | Exception code: 0 none, 1 undefined, 2 reset, 3 fast, 4 normal, 5 data abort, 6 address abort |

## Verification
The bench builds the block with its default parameters. These are a 32-bit address whose top six bits mark an address exception, a 32-byte vector region, 32-bit data and four flags. With these values the address-exception boundary at 0x0400_0000 and the vector region below 0x20 can be reached with short directed vectors, next to ordinary addresses. A scripted coprocessor model answers with busy counts, accept, cannot and runs of increment. This drives the busy-wait cycle counts, every interrupt ranking case and multi-word address sequences, and it injects an abort in the middle of a burst.

// File: rtl/cp_hs_pkg.sv
package cp_hs_pkg;

  typedef enum logic [1:0] {
    RSP_ACCEPT = 2'b00,
    RSP_BUSY   = 2'b01,
    RSP_CANNOT = 2'b10,
    RSP_INC    = 2'b11
  } cp_rsp_e;

  typedef enum logic [2:0] {
    OP_TO_CP   = 3'd0,
    OP_FROM_CP = 3'd1,
    OP_DATA    = 3'd2,
    OP_LOAD    = 3'd3,
    OP_STORE   = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    PH_OFFER = 3'd0,
    PH_POLL  = 3'd1,
    PH_INTR  = 3'd2,
    PH_XFER  = 3'd3,
    PH_DATA  = 3'd4
  } phase_e;

  typedef enum logic [2:0] {
    EXC_NONE   = 3'd0,
    EXC_UNDEF  = 3'd1,
    EXC_RESET  = 3'd2,
    EXC_FIQ    = 3'd3,
    EXC_IRQ    = 3'd4,
    EXC_DABORT = 3'd5,
    EXC_AABORT = 3'd6
  } exc_e;

  typedef enum logic [3:0] {
    S_IDLE, S_ISSUE, S_WAIT, S_POLL, S_NOTIFY, S_XFER, S_ICYC, S_MEM, S_FIN
  } state_e;

endpackage

// File: rtl/cp_hs_irq_arb.sv
module cp_hs_irq_arb
  import cp_hs_pkg::*;
(
  input  logic       rst_req_n,
  input  logic       fiq_n,
  input  logic       irq_n,
  input  logic       f_mask,
  input  logic       i_mask,
  output logic       pending,
  output logic [2:0] code
);

  logic [2:0] req;

  assign req[0] = ~rst_req_n;
  assign req[1] = ~fiq_n & ~f_mask;
  assign req[2] = ~irq_n & ~i_mask;

  always_comb begin
    if (req[0])      code = EXC_RESET;
    else if (req[1]) code = EXC_FIQ;
    else if (req[2]) code = EXC_IRQ;
    else             code = EXC_NONE;
  end

  assign pending = |req;

  always_comb begin
    AST_RANK_FIQ_OVER_IRQ: assert (!(rst_req_n && req[1]) || code == EXC_FIQ); // R5
  end

endmodule

// File: rtl/cp_hs_addr_unit.sv
module cp_hs_addr_unit #(
  parameter int AW             = 32,
  parameter int ADDR_SPACE_BITS = 26,
  parameter int VEC_BYTES      = 32,
  parameter int WORD_BYTES     = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] base_in,
  input  logic          is_store,
  output logic [AW-1:0] addr_q,
  output logic          fault
);

  localparam logic [AW-1:0] STEP_V = AW'(WORD_BYTES);
  localparam logic [AW-1:0] VEC_V  = AW'(VEC_BYTES);

  logic range_fault;

  generate
    if (ADDR_SPACE_BITS < AW) begin : g_range
      assign range_fault = |base_in[AW-1:ADDR_SPACE_BITS];
    end else begin : g_norange
      assign range_fault = 1'b0;
    end
  endgenerate

  assign fault = range_fault | (is_store & (base_in < VEC_V));

  always_ff @(posedge clk) begin
    if (rst)       addr_q <= '0;
    else if (load) addr_q <= base_in;
    else if (step) addr_q <= addr_q + STEP_V;
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> addr_q == $past(addr_q) + STEP_V); // R8

endmodule

// File: rtl/cp_handshake_seq.sv
module cp_handshake_seq
  import cp_hs_pkg::*;
#(
  parameter int IW              = 32,
  parameter int AW              = 32,
  parameter int DW              = 32,
  parameter int FW              = 4,
  parameter int WB_BIT          = 21,
  parameter int ADDR_SPACE_BITS = 26,
  parameter int VEC_BYTES       = 32,
  parameter int WORD_BYTES      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    op_sel,
  input  logic [IW-1:0] instr,
  input  logic [AW-1:0] base_addr,
  input  logic [AW-1:0] wb_value,
  input  logic [DW-1:0] reg_wdata,
  input  logic [FW-1:0] flags,
  input  logic          rst_req_n,
  input  logic          fiq_n,
  input  logic          irq_n,
  input  logic          f_mask,
  input  logic          i_mask,
  output logic          cp_valid,
  output logic [2:0]    cp_phase,
  output logic [IW-1:0] cp_instr,
  input  logic [1:0]    cp_resp,
  output logic [DW-1:0] cp_wdata,
  input  logic [DW-1:0] cp_rdata,
  output logic [DW-1:0] cp_ldata,
  input  logic [DW-1:0] cp_sdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_abort,
  output logic          wb_valid,
  output logic [AW-1:0] wb_data,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          done,
  output logic [2:0]    exc_code
);

  localparam int PAD_W = DW - FW;

  state_e        state;
  op_e           op_q;
  logic [IW-1:0] instr_q;
  logic [AW-1:0] wbv_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic [2:0]    exc_q;
  logic          rdv_q;
  logic          abort_seen;
  logic          wb_q;

  logic          irq_pend;
  logic [2:0]    irq_code;
  logic          addr_fault;
  logic          is_mem_op;
  logic          addr_load;
  logic          addr_step;
  logic [AW-1:0] addr_q;
  op_e           op_in;
  cp_rsp_e       rsp;

  assign op_in     = op_e'(op_sel);
  assign rsp       = cp_rsp_e'(cp_resp);
  assign is_mem_op = (op_in == OP_LOAD) || (op_in == OP_STORE);
  assign addr_load = (state == S_IDLE) && start;
  assign addr_step = (state == S_MEM) && (rsp == RSP_INC);

  cp_hs_irq_arb u_arb (
    .rst_req_n (rst_req_n),
    .fiq_n     (fiq_n),
    .irq_n     (irq_n),
    .f_mask    (f_mask),
    .i_mask    (i_mask),
    .pending   (irq_pend),
    .code      (irq_code)
  );

  cp_hs_addr_unit #(
    .AW              (AW),
    .ADDR_SPACE_BITS (ADDR_SPACE_BITS),
    .VEC_BYTES       (VEC_BYTES),
    .WORD_BYTES      (WORD_BYTES)
  ) u_addr (
    .clk      (clk),
    .rst      (rst),
    .load     (addr_load),
    .step     (addr_step),
    .base_in  (base_addr),
    .is_store (op_in == OP_STORE),
    .addr_q   (addr_q),
    .fault    (addr_fault)
  );

  // Offer/poll outcome, shared by S_ISSUE and S_POLL
  state_e poll_next;
  always_comb begin
    unique case (rsp)
      RSP_BUSY:   poll_next = S_WAIT;
      RSP_CANNOT: poll_next = S_FIN;
      default: begin
        unique case (op_q)
          OP_TO_CP, OP_FROM_CP: poll_next = S_XFER;
          OP_LOAD, OP_STORE:    poll_next = S_MEM;
          default:              poll_next = S_FIN;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      op_q       <= OP_DATA;
      instr_q    <= '0;
      wbv_q      <= '0;
      wdata_q    <= '0;
      rdata_q    <= '0;
      exc_q      <= EXC_NONE;
      rdv_q      <= 1'b0;
      abort_seen <= 1'b0;
      wb_q       <= 1'b0;
    end else begin
      wb_q <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            op_q       <= op_in;
            instr_q    <= instr;
            wbv_q      <= wb_value;
            wdata_q    <= reg_wdata;
            rdv_q      <= 1'b0;
            abort_seen <= 1'b0;
            if (is_mem_op && addr_fault) begin
              exc_q <= EXC_AABORT;
              state <= S_FIN;
            end else begin
              exc_q <= EXC_NONE;
              state <= S_ISSUE;
            end
          end
        end
        S_ISSUE, S_POLL: begin
          state <= poll_next;
          if (rsp == RSP_CANNOT) begin
            exc_q <= EXC_UNDEF;
            if (op_q == OP_FROM_CP) begin
              rdata_q <= {flags, {PAD_W{1'b0}}};
              rdv_q   <= 1'b1;
            end
          end
          if (poll_next == S_MEM) wb_q <= instr_q[WB_BIT];
        end
        S_WAIT: begin
          if (irq_pend) begin
            exc_q <= irq_code;
            state <= S_NOTIFY;
          end else begin
            state <= S_POLL;
          end
        end
        S_NOTIFY: state <= S_FIN;
        S_XFER: begin
          if (op_q == OP_FROM_CP) begin
            rdata_q <= cp_rdata;
            rdv_q   <= 1'b1;
            state   <= S_ICYC;
          end else begin
            state <= S_FIN;
          end
        end
        S_ICYC: state <= S_FIN;
        S_MEM: begin
          if (mem_abort) abort_seen <= 1'b1;
          if (rsp != RSP_INC) begin
            if (mem_abort || abort_seen) exc_q <= EXC_DABORT;
            state <= S_FIN;
          end
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cp_valid = 1'b1;
    cp_phase = PH_OFFER;
    unique case (state)
      S_ISSUE:  cp_phase = PH_OFFER;
      S_POLL:   cp_phase = PH_POLL;
      S_NOTIFY: cp_phase = PH_INTR;
      S_XFER:   cp_phase = PH_XFER;
      S_MEM:    cp_phase = PH_DATA;
      default:  cp_valid = 1'b0;
    endcase
  end

  assign cp_instr  = instr_q;
  assign cp_wdata  = wdata_q;
  assign cp_ldata  = mem_rdata;
  assign mem_req   = (state == S_MEM);
  assign mem_we    = mem_req && (op_q == OP_STORE);
  assign mem_addr  = addr_q;
  assign mem_wdata = cp_sdata;
  assign wb_valid  = wb_q;
  assign wb_data   = wbv_q;
  assign done      = (state == S_FIN);
  assign exc_code  = exc_q;
  assign rd_valid  = done && rdv_q;
  assign rd_data   = rdata_q;

  AST_BUSY_IDLES: assert property (@(posedge clk) disable iff (rst)
    (cp_valid && (cp_phase == PH_OFFER || cp_phase == PH_POLL) && cp_resp == RSP_BUSY)
      |=> !cp_valid); // R3
  AST_NOTIFY_ENDS: assert property (@(posedge clk) disable iff (rst)
    (cp_valid && cp_phase == PH_INTR) |=> (done && exc_code != EXC_NONE && !rd_valid)); // R4
  AST_CANNOT_UNDEF: assert property (@(posedge clk) disable iff (rst)
    (cp_valid && (cp_phase == PH_OFFER || cp_phase == PH_POLL) && cp_resp == RSP_CANNOT)
      |=> (done && exc_code == EXC_UNDEF)); // R6
  AST_WB_IN_DATA: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (mem_req && !$past(mem_req))); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R2

endmodule

// File: tb/tb_cp_handshake_seq.sv
`timescale 1ns/1ps
module tb_cp_handshake_seq;
  import cp_hs_pkg::*;

  localparam int IW = 32, AW = 32, DW = 32, FW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          start = 0;
  logic [2:0]    op_sel = 0;
  logic [IW-1:0] instr = 0;
  logic [AW-1:0] base_addr = 0, wb_value = 0;
  logic [DW-1:0] reg_wdata = 0;
  logic [FW-1:0] flags = 0;
  logic rst_req_n = 1, fiq_n = 1, irq_n = 1, f_mask = 0, i_mask = 0;
  logic          cp_valid;
  logic [2:0]    cp_phase;
  logic [IW-1:0] cp_instr;
  logic [1:0]    cp_resp = RSP_ACCEPT;
  logic [DW-1:0] cp_wdata, cp_rdata = 0, cp_ldata, cp_sdata = 0;
  logic          mem_req, mem_we, mem_abort = 0;
  logic [AW-1:0] mem_addr, wb_data;
  logic [DW-1:0] mem_wdata, mem_rdata = 0, rd_data;
  logic          wb_valid, rd_valid, done;
  logic [2:0]    exc_code;

  cp_handshake_seq dut (.*);

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // results of the last run
  int cycles, idle_cnt, mem_cnt, wb_cnt;
  bit first_ok, intr_seen;
  logic [AW-1:0] addrs [0:15];
  logic [AW-1:0] wb_d;
  logic [DW-1:0] xfer_w, res_rd;
  logic [2:0]    res_exc;
  logic          res_rdv;

  task automatic run_op(input logic [2:0] op, input logic [IW-1:0] ins, input logic [AW-1:0] base,
                        input int busy_n, input logic [1:0] first_rsp, input int inc_n, input int abort_at);
    int busy_left = busy_n;
    int inc_left = inc_n;
    cycles = 0; idle_cnt = 0; mem_cnt = 0; wb_cnt = 0; first_ok = 0; intr_seen = 0;
    wb_d = 0; xfer_w = 0; res_rd = 0; res_exc = 0; res_rdv = 0;
    @(negedge clk);
    op_sel = op; instr = ins; base_addr = base; start = 1;
    cp_resp = RSP_ACCEPT;
    @(negedge clk);
    start = 0;
    while (cycles < 200) begin
      cycles++;
      mem_abort = 0;
      if (!cp_valid && !done) idle_cnt++;
      if (cp_valid && cp_phase == PH_OFFER && cp_instr == ins) first_ok = 1;
      if (cp_valid && cp_phase == PH_INTR) intr_seen = 1;
      if (cp_valid && cp_phase == PH_XFER) xfer_w = cp_wdata;
      if (wb_valid) begin wb_cnt++; wb_d = wb_data; end
      if (mem_req) begin
        if (mem_cnt < 16) addrs[mem_cnt] = mem_addr;
        mem_abort = (mem_cnt == abort_at);
        mem_cnt++;
      end
      if (done) begin
        res_exc = exc_code; res_rd = rd_data; res_rdv = rd_valid;
        break;
      end
      if (cp_valid && (cp_phase == PH_OFFER || cp_phase == PH_POLL)) begin
        if (busy_left > 0) begin cp_resp = RSP_BUSY; busy_left--; end
        else cp_resp = first_rsp;
      end else if (cp_valid && cp_phase == PH_DATA) begin
        if (inc_left > 0) begin cp_resp = RSP_INC; inc_left--; end
        else cp_resp = RSP_ACCEPT;
      end else cp_resp = RSP_ACCEPT;
      @(negedge clk);
    end
    mem_abort = 0;
    cp_resp = RSP_ACCEPT;
  endtask

  task automatic t_reset;
    chk("R1", "cp_valid", cp_valid, 0);
    chk("R1", "mem_req", mem_req, 0);
    chk("R1", "wb_valid", wb_valid, 0);
    chk("R1", "rd_valid", rd_valid, 0);
    chk("R1", "done", done, 0);
  endtask

  task automatic t_data_accept;
    run_op(OP_DATA, 32'h0E00_1234, 0, 0, RSP_ACCEPT, 0, -1);
    chk("R2", "offer seen", first_ok, 1);
    chk("R2", "cycles", cycles, 2);
    chk("R2", "exc", res_exc, EXC_NONE);
  endtask

  task automatic t_busy_wait;
    run_op(OP_DATA, 32'h0E00_5555, 0, 3, RSP_ACCEPT, 0, -1);
    chk("R3", "cycles", cycles, 8);
    chk("R3", "idle cycles", idle_cnt, 3);
    chk("R3", "exc", res_exc, EXC_NONE);
  endtask

  task automatic t_irq_cancel;
    fiq_n = 0; f_mask = 0;
    run_op(OP_FROM_CP, 32'h0E10_0001, 0, 1000, RSP_ACCEPT, 0, -1);
    fiq_n = 1;
    chk("R4", "cycles", cycles, 4);
    chk("R4", "notice", intr_seen, 1);
    chk("R4", "exc", res_exc, EXC_FIQ);
    chk("R4", "rd_valid", res_rdv, 0);
  endtask

  task automatic t_priority;
    rst_req_n = 0; fiq_n = 0; irq_n = 0;
    run_op(OP_DATA, 32'h1, 0, 1000, RSP_ACCEPT, 0, -1);
    chk("R5", "reset first", res_exc, EXC_RESET);
    rst_req_n = 1; f_mask = 1;
    run_op(OP_DATA, 32'h2, 0, 1000, RSP_ACCEPT, 0, -1);
    chk("R5", "masked fast, normal wins", res_exc, EXC_IRQ);
    i_mask = 1;
    run_op(OP_DATA, 32'h3, 0, 2, RSP_ACCEPT, 0, -1);
    chk("R5", "all masked exc", res_exc, EXC_NONE);
    chk("R5", "all masked cycles", cycles, 6);
    chk("R5", "all masked notice", intr_seen, 0);
    fiq_n = 1; irq_n = 1; f_mask = 0; i_mask = 0;
  endtask

  task automatic t_cannot;
    flags = 4'hA;
    run_op(OP_FROM_CP, 32'h4, 0, 1, RSP_CANNOT, 0, -1);
    chk("R6", "read exc", res_exc, EXC_UNDEF);
    chk("R6", "read rd_valid", res_rdv, 1);
    chk("R6", "read flags", res_rd, 32'hA000_0000);
    run_op(OP_DATA, 32'h5, 0, 0, RSP_CANNOT, 0, -1);
    chk("R6", "data exc", res_exc, EXC_UNDEF);
    chk("R6", "data rd_valid", res_rdv, 0);
  endtask

  task automatic t_reg_xfer;
    reg_wdata = 32'hDEAD_BEEF;
    run_op(OP_TO_CP, 32'h6, 0, 0, RSP_ACCEPT, 0, -1);
    chk("R7", "send cycles", cycles, 3);
    chk("R7", "send data", xfer_w, 32'hDEAD_BEEF);
    cp_rdata = 32'h1357_9BDF;
    run_op(OP_FROM_CP, 32'h7, 0, 0, RSP_ACCEPT, 0, -1);
    chk("R7", "read cycles", cycles, 4);
    chk("R7", "read data", res_rd, 32'h1357_9BDF);
    chk("R7", "read valid", res_rdv, 1);
  endtask

  task automatic t_burst;
    run_op(OP_LOAD, 32'h0, 32'h100, 0, RSP_ACCEPT, 3, -1);
    chk("R8", "words", mem_cnt, 4);
    for (int i = 0; i < 4; i++) chk("R8", "addr", addrs[i], 32'h100 + 4 * i);
    chk("R8", "cycles", cycles, 6);
    chk("R10", "no writeback without bit 21", wb_cnt, 0);
    run_op(OP_STORE, 32'h0, 32'h200, 0, RSP_ACCEPT, 0, -1);
    chk("R8", "single store words", mem_cnt, 1);
    chk("R8", "single store addr", addrs[0], 32'h200);
  endtask

  task automatic t_addr_fault;
    run_op(OP_LOAD, 32'h0, 32'h0400_0000, 0, RSP_ACCEPT, 0, -1);
    chk("R9", "range exc", res_exc, EXC_AABORT);
    chk("R9", "range cycles", cycles, 1);
    chk("R9", "range words", mem_cnt, 0);
    run_op(OP_STORE, 32'h0, 32'h10, 0, RSP_ACCEPT, 0, -1);
    chk("R9", "vector store exc", res_exc, EXC_AABORT);
    run_op(OP_LOAD, 32'h0, 32'h10, 0, RSP_ACCEPT, 0, -1);
    chk("R9", "vector load exc", res_exc, EXC_NONE);
    chk("R9", "vector load words", mem_cnt, 1);
  endtask

  task automatic t_writeback;
    wb_value = 32'h0000_ABCD;
    run_op(OP_LOAD, 32'h0020_0000, 32'h300, 0, RSP_ACCEPT, 1, -1);
    chk("R10", "wb pulses", wb_cnt, 1);
    chk("R10", "wb data", wb_d, 32'h0000_ABCD);
  endtask

  task automatic t_mem_abort;
    run_op(OP_LOAD, 32'h0, 32'h400, 0, RSP_ACCEPT, 2, 1);
    chk("R11", "exc", res_exc, EXC_DABORT);
    chk("R11", "words", mem_cnt, 3);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_data_accept();
    t_busy_wait();
    t_irq_cancel();
    t_priority();
    t_cannot();
    t_reg_xfer();
    t_burst();
    t_addr_fault();
    t_writeback();
    t_mem_abort();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule